// File: doc/BRIEF.md
# Two-Pass Register-Pair Multiply-Accumulate Unit

This execution unit runs a single integer instruction: a full-width multiply of two 32-bit registers whose 64-bit product is added to a 64-bit accumulator. The accumulator is held in a pair of registers that the instruction both reads and writes. The 32-bit instruction word carries four 5-bit register indices. Two of them name the multiplicands. The other two name the high and low halves of the accumulator pair.

The unit is attached to a register file that gives it only two read ports. It uses those ports twice. In the first read cycle it fetches the multiplicands, so the three-stage multiplier can start at once. In the next cycle it fetches the accumulator pair on the same ports, because the accumulator is only needed in the last multiplier stage. Both halves of the result are written back together in one writeback cycle. A busy flag covers the whole operation, from acceptance to writeback. While it is set, further issue requests are refused.

Top module: `pair_mac_unit`

## Requirements
- R1: Instruction fields are: accumulator-high index at bits [31:27], accumulator-low index at [26:22], multiplicand A index at [21:17], multiplicand B index at [16:12], and the signed-mode flag at bit 0 (1 = two's complement, 0 = unsigned). Bits [11:1] have no effect.
- R2: An instruction is accepted at a clock edge where `issue_valid` and `issue_ready` are both high. `busy` is high from the cycle after acceptance through the writeback cycle. While `busy` is high, `issue_ready` is low and requests are ignored: they cause no extra read and no extra writeback.
- R3: In the cycle after acceptance, `rd_valid` is high, `rd_addr_a` holds the A index and `rd_addr_b` holds the B index.
- R4: In the cycle after that, `rd_valid` is high with `rd_addr_a` = accumulator-high index and `rd_addr_b` = accumulator-low index. The data for each request must arrive on `rd_data_a`/`rd_data_b` exactly one cycle after the request.
- R5: `wb_valid` is high for exactly one cycle, the fifth cycle after acceptance. In that cycle `wb_addr_hi` and `wb_addr_lo` carry the accumulator indices.
- R6: In unsigned mode, {wb_data_hi, wb_data_lo} = {acc_hi, acc_lo} + A × B, taken modulo 2^64, with both operands zero-extended.
- R7: In signed mode, the product is the two's-complement product of A and B, sign-extended to 64 bits before the add.
- R8: A carry out of the low half is added into the high half. A carry out of bit 63 is discarded.
- R9: If a multiplicand index equals an accumulator index, the multiplicand value used is the one read before the update.
- R10: `issue_ready` is high again in the cycle after writeback, so a new instruction can be accepted in that cycle.
- R11: After reset, `busy`, `rd_valid` and `wb_valid` are low and `issue_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Issue request |
| issue_instr | input | 32 | Instruction word |
| issue_ready | output | 1 | Unit can accept an instruction |
| busy | output | 1 | Operation in flight |
| rd_valid | output | 1 | Read request strobe for both ports |
| rd_addr_a | output | 5 | Read port A register index |
| rd_addr_b | output | 5 | Read port B register index |
| rd_data_a | input | 32 | Read port A data, one cycle after request |
| rd_data_b | input | 32 | Read port B data, one cycle after request |
| wb_valid | output | 1 | Writeback strobe |
| wb_addr_hi | output | 5 | Register index for the high half |
| wb_addr_lo | output | 5 | Register index for the low half |
| wb_data_hi | output | 32 | Result high half |
| wb_data_lo | output | 32 | Result low half |

## Verification
The assertions assume the register file returns data for each read strobe exactly one cycle later. They also assume no other writer changes the named registers between the operand read and the writeback. The result-value property depends on both of these assumptions. The bench models its register file with a one-cycle registered read and with writes only from this unit's writeback port. It loads register values only while the unit is idle, so its stimulus stays inside these assumptions.

// File: rtl/pmac_pkg.sv
// Package: shared widths, instruction field positions and the decoded
// operation record for the two-pass multiply-accumulate unit.
package pmac_pkg;
    localparam int XLEN    = 32;           // register width
    localparam int RIDX_W  = 5;            // register index width
    localparam int INSTR_W = 32;           // instruction word width
    localparam int HI_POS  = 27;           // accumulator-high index LSB
    localparam int LO_POS  = 22;           // accumulator-low index LSB
    localparam int A_POS   = 17;           // multiplicand A index LSB
    localparam int B_POS   = 12;           // multiplicand B index LSB
    localparam int SGN_POS = 0;            // signed-mode flag
    localparam int LAT     = 5;            // cycles from acceptance to writeback
    localparam int PH_OPR  = 1;            // phase reading multiplicands
    localparam int PH_ACC  = 2;            // phase reading accumulator pair
    localparam int PH_PP   = 3;            // phase capturing partial products
    localparam int PH_SUM  = 4;            // phase forming the final sum

    typedef struct packed {
        logic [RIDX_W-1:0] acc_hi;
        logic [RIDX_W-1:0] acc_lo;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic              is_signed;
    } pmac_op_t;

    // Pull the register indices and mode flag out of an instruction word.
    function automatic pmac_op_t decode_op(input logic [INSTR_W-1:0] w);
        pmac_op_t o;
        o.acc_hi    = w[HI_POS +: RIDX_W];
        o.acc_lo    = w[LO_POS +: RIDX_W];
        o.src_a     = w[A_POS  +: RIDX_W];
        o.src_b     = w[B_POS  +: RIDX_W];
        o.is_signed = w[SGN_POS];
        return o;
    endfunction
endpackage

// File: rtl/pmac_phase_ctrl.sv
// Phase sequencer: a one-hot shift chain that marks which step of the
// operation is active. Assumes acceptance is gated by the caller so at most
// one token is in the chain at any time.
module pmac_phase_ctrl
    import pmac_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    output logic [LAT:1] phase,
    output logic         busy
);
    // Advance the token one step per cycle; load it on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= {phase[LAT-1:1], accept};
    end

    // Busy while any phase is active.
    always_comb busy = |phase;
endmodule

// File: rtl/pmac_port_sched.sv
// Read-port scheduler: drives the two shared read ports with the multiplicand
// indices in the first read phase and the accumulator pair in the second.
// Assumes the two phase inputs are never high together.
module pmac_port_sched
    import pmac_pkg::*;
(
    input  pmac_op_t          op,
    input  logic              ph_opr,
    input  logic              ph_acc,
    output logic              rd_valid,
    output logic [RIDX_W-1:0] rd_addr_a,
    output logic [RIDX_W-1:0] rd_addr_b
);
    // Pick the index pair for the active read phase.
    always_comb begin
        rd_valid  = ph_opr | ph_acc;
        rd_addr_a = '0;
        rd_addr_b = '0;
        if (ph_opr) begin
            rd_addr_a = op.src_a;
            rd_addr_b = op.src_b;
        end else if (ph_acc) begin
            rd_addr_a = op.acc_hi;
            rd_addr_b = op.acc_lo;
        end
    end
endmodule

// File: rtl/pmac_mult_stages.sv
// First two multiplier stages. Stage one latches the operands and mode.
// Stage two forms four half-width unsigned partial products plus a signed
// correction term, to be subtracted from the upper half. Assumes W is even.
module pmac_mult_stages #(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_opr,
    input  logic              ld_pp,
    input  logic [W-1:0]      a_in,
    input  logic [W-1:0]      b_in,
    input  logic              sgn_in,
    output logic [3:0][W-1:0] pp,
    output logic [W-1:0]      corr
);
    localparam int HW = W / 2;

    logic [W-1:0]      opa, opb;
    logic              sg;
    logic [3:0][W-1:0] pp_nx;
    logic [W-1:0]      corr_nx;

    // Stage one: capture the multiplicands as they arrive from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa <= '0;
            opb <= '0;
            sg  <= 1'b0;
        end else if (ld_opr) begin
            opa <= a_in;
            opb <= b_in;
            sg  <= sgn_in;
        end
    end

    // Partial products, index = 2*(A half) + (B half).
    for (genvar i = 0; i < 2; i++) begin : g_ah
        for (genvar j = 0; j < 2; j++) begin : g_bh
            assign pp_nx[i*2+j] = W'(opa[i*HW +: HW]) * W'(opb[j*HW +: HW]);
        end
    end

    // Signed correction: subtract each operand shifted up when the other is negative.
    always_comb begin
        corr_nx = '0;
        if (sg && opa[W-1]) corr_nx = corr_nx + opb;
        if (sg && opb[W-1]) corr_nx = corr_nx + opa;
    end

    // Stage two: register partial products and correction term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp   <= '0;
            corr <= '0;
        end else if (ld_pp) begin
            pp   <= pp_nx;
            corr <= corr_nx;
        end
    end
endmodule

// File: rtl/pmac_accum.sv
// Final stage: captures the accumulator pair from the read ports, merges the
// partial products, and adds the pair with an explicit carry from the low
// half into the high half. Overflow beyond 2*W bits is dropped.
module pmac_accum #(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_acc,
    input  logic              ld_res,
    input  logic [W-1:0]      acc_hi_in,
    input  logic [W-1:0]      acc_lo_in,
    input  logic [3:0][W-1:0] pp,
    input  logic [W-1:0]      corr,
    output logic [W-1:0]      res_hi,
    output logic [W-1:0]      res_lo
);
    localparam int HW = W / 2;
    localparam int DW = 2 * W;

    logic [W-1:0]  acc_hi_q, acc_lo_q;
    logic [DW-1:0] prod_w;
    logic [W:0]    lo_sum;
    logic [W-1:0]  hi_sum;

    // Hold the accumulator pair read in the second port pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi_q <= '0;
            acc_lo_q <= '0;
        end else if (ld_acc) begin
            acc_hi_q <= acc_hi_in;
            acc_lo_q <= acc_lo_in;
        end
    end

    // Merge partial products and apply the signed correction.
    always_comb begin
        prod_w = {pp[3], {W{1'b0}}}
               + ({{W{1'b0}}, pp[1]} << HW)
               + ({{W{1'b0}}, pp[2]} << HW)
               + {{W{1'b0}}, pp[0]}
               - {corr, {W{1'b0}}};
    end

    // Split add: low half with carry out, carry folded into the high half.
    always_comb begin
        lo_sum = {1'b0, prod_w[W-1:0]} + {1'b0, acc_lo_q};
        hi_sum = prod_w[DW-1:W] + acc_hi_q + W'(lo_sum[W]);
    end

    // Register the result for the writeback cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
        end else if (ld_res) begin
            res_hi <= hi_sum;
            res_lo <= lo_sum[W-1:0];
        end
    end
endmodule

// File: rtl/pair_mac_unit.sv
// Top level: accepts one instruction at a time, reads the multiplicands and
// then the accumulator pair over two shared read ports, and writes both result
// halves back in one cycle. Assumes read data returns one cycle after each
// request and no other writer touches the named registers meanwhile.
module pair_mac_unit
    import pmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [INSTR_W-1:0] issue_instr,
    output logic               issue_ready,
    output logic               busy,
    output logic               rd_valid,
    output logic [RIDX_W-1:0]  rd_addr_a,
    output logic [RIDX_W-1:0]  rd_addr_b,
    input  logic [XLEN-1:0]    rd_data_a,
    input  logic [XLEN-1:0]    rd_data_b,
    output logic               wb_valid,
    output logic [RIDX_W-1:0]  wb_addr_hi,
    output logic [RIDX_W-1:0]  wb_addr_lo,
    output logic [XLEN-1:0]    wb_data_hi,
    output logic [XLEN-1:0]    wb_data_lo
);
    logic                 accept;
    logic [LAT:1]         phase;
    pmac_op_t             op_q;
    logic [3:0][XLEN-1:0] pp;
    logic [XLEN-1:0]      corr;
    logic                 unused_instr_bits;

    assign unused_instr_bits = ^issue_instr[B_POS-1:SGN_POS+1];

    // Accept only while idle.
    always_comb begin
        issue_ready = ~busy;
        accept      = issue_valid & ~busy;
    end

    // Hold the decoded instruction for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n)      op_q <= '0;
        else if (accept) op_q <= decode_op(issue_instr);
    end

    pmac_phase_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .phase  (phase),
        .busy   (busy)
    );

    pmac_port_sched u_sched (
        .op        (op_q),
        .ph_opr    (phase[PH_OPR]),
        .ph_acc    (phase[PH_ACC]),
        .rd_valid  (rd_valid),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b)
    );

    pmac_mult_stages #(.W(XLEN)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_opr (phase[PH_ACC]),
        .ld_pp  (phase[PH_PP]),
        .a_in   (rd_data_a),
        .b_in   (rd_data_b),
        .sgn_in (op_q.is_signed),
        .pp     (pp),
        .corr   (corr)
    );

    pmac_accum #(.W(XLEN)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_acc    (phase[PH_PP]),
        .ld_res    (phase[PH_SUM]),
        .acc_hi_in (rd_data_a),
        .acc_lo_in (rd_data_b),
        .pp        (pp),
        .corr      (corr),
        .res_hi    (wb_data_hi),
        .res_lo    (wb_data_lo)
    );

    // Writeback strobe and destination indices.
    always_comb begin
        wb_valid   = phase[LAT];
        wb_addr_hi = op_q.acc_hi;
        wb_addr_lo = op_q.acc_lo;
    end
endmodule

// File: rtl/pair_mac_unit_chk.sv
// Checker for pair_mac_unit: port-level timing and result properties.
// Assumes read data arrives one cycle after each request.
module pair_mac_unit_chk
    import pmac_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid,
    input logic [INSTR_W-1:0] issue_instr,
    input logic               issue_ready,
    input logic               busy,
    input logic               rd_valid,
    input logic [RIDX_W-1:0]  rd_addr_a,
    input logic [RIDX_W-1:0]  rd_addr_b,
    input logic [XLEN-1:0]    rd_data_a,
    input logic [XLEN-1:0]    rd_data_b,
    input logic               wb_valid,
    input logic [RIDX_W-1:0]  wb_addr_hi,
    input logic [RIDX_W-1:0]  wb_addr_lo,
    input logic [XLEN-1:0]    wb_data_hi,
    input logic [XLEN-1:0]    wb_data_lo
);
    logic              acc_evt;
    logic [XLEN-1:0]   ha1, hb1, ha2, hb2, ha3, hb3;
    logic              ck_sgn;
    logic [2*XLEN-1:0] ck_prod, ck_exp;

    assign acc_evt = issue_valid && issue_ready;

    // History of read data and the accepted mode flag.
    always_ff @(posedge clk) begin
        ha1 <= rd_data_a; hb1 <= rd_data_b;
        ha2 <= ha1;       hb2 <= hb1;
        ha3 <= ha2;       hb3 <= hb2;
        if (!rst_n)       ck_sgn <= 1'b0;
        else if (acc_evt) ck_sgn <= issue_instr[SGN_POS];
    end

    // Reference result from the operand and accumulator history.
    always_comb begin
        if (ck_sgn)
            ck_prod = 64'($signed({{XLEN{ha3[XLEN-1]}}, ha3}) * $signed({{XLEN{hb3[XLEN-1]}}, hb3}));
        else
            ck_prod = {{XLEN{1'b0}}, ha3} * {{XLEN{1'b0}}, hb3};
        ck_exp = {ha2, hb2} + ck_prod;
    end

    assert_opr_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_evt |=> (rd_valid && busy && rd_addr_a == $past(issue_instr[A_POS +: RIDX_W])
                     && rd_addr_b == $past(issue_instr[B_POS +: RIDX_W])));

    assert_acc_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_evt |=> ##1 (rd_valid && rd_addr_a == $past(issue_instr[HI_POS +: RIDX_W], 2)
                         && rd_addr_b == $past(issue_instr[LO_POS +: RIDX_W], 2)));

    assert_wb_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_evt |=> ##4 (wb_valid && wb_addr_hi == $past(issue_instr[HI_POS +: RIDX_W], 5)
                         && wb_addr_lo == $past(issue_instr[LO_POS +: RIDX_W], 5)));

    assert_wb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    assert_ready_after_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (!busy && issue_ready));

    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb_valid) |=> busy);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_valid && !wb_valid));

    assert_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ({wb_data_hi, wb_data_lo} == ck_exp));
endmodule

bind pair_mac_unit pair_mac_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_instr (issue_instr),
    .issue_ready (issue_ready),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .rd_addr_a   (rd_addr_a),
    .rd_addr_b   (rd_addr_b),
    .rd_data_a   (rd_data_a),
    .rd_data_b   (rd_data_b),
    .wb_valid    (wb_valid),
    .wb_addr_hi  (wb_addr_hi),
    .wb_addr_lo  (wb_addr_lo),
    .wb_data_hi  (wb_data_hi),
    .wb_data_lo  (wb_data_lo)
);

// File: tb/tb_pair_mac_unit.sv
// Directed bench: a registered-read register file model, one task per scenario.
module tb_pair_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_instr = '0;
    logic        issue_ready, busy, rd_valid, wb_valid;
    logic [4:0]  rd_addr_a, rd_addr_b, wb_addr_hi, wb_addr_lo;
    logic [31:0] rd_data_a = '0, rd_data_b = '0;
    logic [31:0] wb_data_hi, wb_data_lo;

    logic        pre_we = 1'b0;
    logic [4:0]  pre_addr = '0;
    logic [31:0] pre_data = '0;
    logic [31:0] rf [32];
    logic [31:0] shadow [32];
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pair_mac_unit dut (.*);

    // Register file: registered read, writes from the unit or the bench preload.
    always @(posedge clk) begin
        if (rd_valid) begin
            rd_data_a <= rf[rd_addr_a];
            rd_data_b <= rf[rd_addr_b];
        end
        if (wb_valid) begin
            rf[wb_addr_hi] <= wb_data_hi;
            rf[wb_addr_lo] <= wb_data_lo;
        end
        if (pre_we) rf[pre_addr] <= pre_data;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [4:0] idx, input logic [31:0] val);
        pre_we = 1'b1; pre_addr = idx; pre_data = val;
        @(negedge clk);
        pre_we = 1'b0;
        shadow[idx] = val;
    endtask

    // One full operation, started at a negedge while idle; optional intrusion.
    task automatic do_op(input logic [4:0] hi, input logic [4:0] lo, input logic [4:0] a,
                         input logic [4:0] b, input bit sgn, input logic [10:0] junk,
                         input bit intrude, input string req);
        logic [63:0] prod, exp;
        longint sa, sb;
        if (sgn) begin
            sa = $signed(shadow[a]);
            sb = $signed(shadow[b]);
            prod = 64'(sa * sb);
        end else begin
            prod = {32'h0, shadow[a]} * {32'h0, shadow[b]};
        end
        exp = {shadow[hi], shadow[lo]} + prod;
        check(issue_ready == 1'b1, "R2 ready idle", 64'(issue_ready), 64'd1);
        issue_valid = 1'b1;
        issue_instr = {hi, lo, a, b, junk, sgn};
        @(negedge clk);
        issue_valid = 1'b0;
        check(rd_valid && busy && rd_addr_a == a && rd_addr_b == b, "R3 operand read (R1 fields)",
              64'({rd_valid, busy, rd_addr_a, rd_addr_b}), 64'({2'b11, a, b}));
        @(negedge clk);
        check(rd_valid && rd_addr_a == hi && rd_addr_b == lo, "R4 accumulator read",
              64'({rd_valid, rd_addr_a, rd_addr_b}), 64'({1'b1, hi, lo}));
        if (intrude) begin
            check(issue_ready == 1'b0, "R2 ready low while busy", 64'(issue_ready), 64'd0);
            issue_valid = 1'b1;
            issue_instr = {5'd30, 5'd31, 5'd30, 5'd31, 11'h0, 1'b0};
        end
        @(negedge clk);
        issue_valid = 1'b0;
        check(!rd_valid && !wb_valid, "R2 no third read", 64'({rd_valid, wb_valid}), 64'd0);
        @(negedge clk);
        check(!wb_valid && busy, "R5 no early writeback", 64'({wb_valid, busy}), 64'b01);
        @(negedge clk);
        check(wb_valid && busy && wb_addr_hi == hi && wb_addr_lo == lo, "R5 writeback timing",
              64'({wb_valid, busy, wb_addr_hi, wb_addr_lo}), 64'({2'b11, hi, lo}));
        check({wb_data_hi, wb_data_lo} == exp, req, {wb_data_hi, wb_data_lo}, exp);
        shadow[hi] = exp[63:32];
        shadow[lo] = exp[31:0];
        @(negedge clk);
        check(!busy && issue_ready && !wb_valid, "R10 ready after writeback",
              64'({busy, issue_ready, wb_valid}), 64'b010);
    endtask

    task automatic t_reset;
        check(!busy && issue_ready && !rd_valid && !wb_valid, "R11 reset state",
              64'({busy, issue_ready, rd_valid, wb_valid}), 64'b0100);
    endtask

    task automatic t_unsigned;
        poke(5'd1, 32'd1234); poke(5'd2, 32'd5678); poke(5'd10, 32'd7); poke(5'd11, 32'd99);
        do_op(5'd10, 5'd11, 5'd1, 5'd2, 1'b0, 11'h000, 1'b0, "R6 unsigned small");
        poke(5'd3, 32'hFFFF_FFFF); poke(5'd4, 32'hFFFF_FFFF); poke(5'd12, 32'h0); poke(5'd13, 32'h0);
        do_op(5'd12, 5'd13, 5'd3, 5'd4, 1'b0, 11'h7FF, 1'b0, "R6 unsigned max (R1 junk bits)");
    endtask

    task automatic t_signed;
        poke(5'd5, 32'hFFFF_FFFD); poke(5'd6, 32'd1000); poke(5'd14, 32'h0); poke(5'd15, 32'd50);
        do_op(5'd14, 5'd15, 5'd5, 5'd6, 1'b1, 11'h2A5, 1'b0, "R7 signed neg*pos");
        poke(5'd7, 32'h8000_0000); poke(5'd8, 32'h8000_0000);
        do_op(5'd14, 5'd15, 5'd7, 5'd8, 1'b1, 11'h000, 1'b0, "R7 signed min*min");
        poke(5'd7, 32'hFFFF_FFFF);
        do_op(5'd14, 5'd15, 5'd7, 5'd8, 1'b0, 11'h000, 1'b0, "R6 same regs unsigned mode");
    endtask

    task automatic t_carry;
        poke(5'd1, 32'd1); poke(5'd2, 32'd1); poke(5'd16, 32'h0000_0005); poke(5'd17, 32'hFFFF_FFFF);
        do_op(5'd16, 5'd17, 5'd1, 5'd2, 1'b0, 11'h000, 1'b0, "R8 low-half carry");
        poke(5'd16, 32'hFFFF_FFFF); poke(5'd17, 32'hFFFF_FFFF);
        do_op(5'd16, 5'd17, 5'd1, 5'd2, 1'b0, 11'h000, 1'b0, "R8 top carry dropped");
    endtask

    task automatic t_alias;
        poke(5'd20, 32'hFFFF_FFF0); poke(5'd21, 32'h0001_0003);
        do_op(5'd20, 5'd21, 5'd20, 5'd21, 1'b1, 11'h000, 1'b0, "R9 multiplicands alias accumulator");
        do_op(5'd20, 5'd21, 5'd21, 5'd20, 1'b0, 11'h000, 1'b0, "R9 alias back-to-back R10");
    endtask

    task automatic t_intrude;
        poke(5'd30, 32'h1111_1111); poke(5'd31, 32'h2222_2222);
        poke(5'd1, 32'd3); poke(5'd2, 32'd4);
        do_op(5'd22, 5'd23, 5'd1, 5'd2, 1'b0, 11'h000, 1'b1, "R2 result with ignored issue");
        for (int k = 0; k < 8; k++) begin
            check(!rd_valid && !wb_valid && !busy, "R2 ignored issue leaves unit idle",
                  64'({rd_valid, wb_valid, busy}), 64'd0);
            @(negedge clk);
        end
        do_op(5'd30, 5'd31, 5'd1, 5'd2, 1'b0, 11'h000, 1'b0, "R2 untouched pair 30/31");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) shadow[i] = 32'h0;
        for (int i = 0; i < 32; i++) rf[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_carry();
        t_alias();
        t_intrude();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule